// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 16-bit, word-addressed processor and decides where execution goes after each instruction. When the execute strobe is high it looks at the instruction word and picks one of five outcomes. It can fall through to the next word. It can take a conditional branch that compares a three-bit mask against the one-hot N/Z/P flags. It can jump to an address held in a base register. It can call a subroutine by a PC-relative offset or through a base register. It can start a system-call trap.

Calls and traps also ask the register file to write the return address into register 7. A trap does not finish in one cycle. The unit first sends out a single read of the vector table in low memory. It then waits for the read data to come back and loads that word into the PC. During that wait the unit ignores any new instruction.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc` becomes x3000 and `mem_rd_req` becomes 0. `link_we` stays low while no strobe and no read data are present.
- R2: An instruction with opcode `instr[15:12]`=0000 is a conditional branch. Its mask `instr[11:9]` is ordered n,z,p and matches `flags_nzp` bit for bit. If the mask AND the flags is non-zero, the next `pc` is `pc+1+sext(instr[8:0])`. Otherwise the next `pc` is `pc+1`.
- R3: A branch mask of 000 never branches, whatever the flags are. A branch mask of 111 always branches for any one-hot flag value.
- R4: Opcode 1100 loads `pc` from `base_val`, the value of the register named by `instr[8:6]`. It does not raise `link_we`. A return is this same jump with register 7 as the base.
- R5: Opcode 0100 is a call. With `instr[11]`=1 the target is `pc+1+sext(instr[10:0])`. With `instr[11]`=0 the target is `base_val`. In the strobe cycle `link_we` is 1 and `link_data` equals `pc+1`.
- R6: Opcode 1111 is a trap. The strobe leaves `pc` unchanged. From the next cycle, `mem_rd_req` is 1 and `mem_rd_addr` is `{8'h00, instr[7:0]}`. The request and `pc` hold until `mem_rd_valid` arrives.
- R7: When `mem_rd_valid` is 1 while a request is open, `link_we` is 1 in that cycle and `link_data` is the trap address plus one. At that edge `pc` takes `mem_rd_data`, and `mem_rd_req` drops after the edge.
- R8: With `exec_en` low, `pc` does not change. While a trap request is open, `exec_en` has no effect. Outside a request, `mem_rd_valid` has no effect.
- R9: Any other opcode (for example 0001) advances `pc` to `pc+1` and does not raise `link_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_en | input | 1 | Execute strobe; the instruction is acted on at this edge |
| instr | input | 16 | Instruction word |
| flags_nzp | input | 3 | Stored condition flags, one-hot, order n,z,p |
| base_val | input | 16 | Value of the base register named by the instruction |
| pc | output | 16 | Current program counter |
| link_we | output | 1 | Request to write the return address into register 7 |
| link_data | output | 16 | Return address for the link write |
| mem_rd_req | output | 1 | Vector table read request, held until data returns |
| mem_rd_addr | output | 16 | Vector table address |
| mem_rd_data | input | 16 | Read data from memory |
| mem_rd_valid | input | 1 | Read data is valid this cycle |

## Verification
The link write and the base-register read can fall in the same cycle. A register-based call through register 7 reads the old R7 as its target while it writes the new return address. The bench issues such a call with a `base_val` that is different from the return address. It expects the PC to take the old value and `link_data` to show `pc+1` in that same cycle. A second overlap, a new strobe arriving while the trap is waiting, is provoked by driving a jump during the wait and judged by the PC staying put until the vector arrives.

// File: rtl/npc_pkg.sv
// Package: shared opcode constants and the control-flow class type
// for the next-PC unit.
package npc_pkg;

    // Opcodes in instr[15:12] that the unit decodes
    localparam logic [3:0] OP_BRANCH = 4'b0000;
    localparam logic [3:0] OP_CALL   = 4'b0100;
    localparam logic [3:0] OP_JUMP   = 4'b1100;
    localparam logic [3:0] OP_TRAP   = 4'b1111;

    // Control-flow class chosen for the current instruction
    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BRANCH,
        FLOW_JUMP,
        FLOW_CALL_REL,
        FLOW_CALL_REG,
        FLOW_TRAP
    } flow_e;

endpackage

// File: rtl/npc_decode.sv
// Module: npc_decode
// Classifies the instruction into a control-flow class. A conditional
// branch whose mask does not meet the current flags is classed as
// sequential.
// Assumes: flags are one-hot with order n,z,p, matching mask bits [11:9].
module npc_decode
    import npc_pkg::*;
(
    input  logic [6:0] instr_hi,   // instr[15:9]
    input  logic [2:0] flags_nzp,
    output flow_e      kind
);
    logic [3:0] opcode;
    logic [2:0] cond_mask;
    logic       cond_hit;

    assign opcode    = instr_hi[6:3];
    assign cond_mask = instr_hi[2:0];
    assign cond_hit  = |(cond_mask & flags_nzp);

    // Map opcode and condition outcome to a flow class
    always_comb begin
        unique case (opcode)
            OP_BRANCH: kind = cond_hit ? FLOW_BRANCH : FLOW_SEQ;
            OP_JUMP:   kind = FLOW_JUMP;
            OP_CALL:   kind = instr_hi[2] ? FLOW_CALL_REL : FLOW_CALL_REG;
            OP_TRAP:   kind = FLOW_TRAP;
            default:   kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
// Module: npc_target
// Computes the next PC for every single-cycle flow class.
// Assumes: pc_inc is the address of the current instruction plus one.
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN    = 16,
    parameter int BR_OFFW = 9,
    parameter int CL_OFFW = 11
) (
    input  logic [XLEN-1:0]    pc_inc,
    input  logic [CL_OFFW-1:0] offset_bits,  // instr[10:0]
    input  logic [XLEN-1:0]    base_val,
    input  flow_e              kind,
    output logic [XLEN-1:0]    target
);
    localparam int BR_EXT = XLEN - BR_OFFW;
    localparam int CL_EXT = XLEN - CL_OFFW;

    logic [XLEN-1:0] br_sext;
    logic [XLEN-1:0] cl_sext;

    assign br_sext = {{BR_EXT{offset_bits[BR_OFFW-1]}}, offset_bits[BR_OFFW-1:0]};
    assign cl_sext = {{CL_EXT{offset_bits[CL_OFFW-1]}}, offset_bits};

    // Select the target address for the flow class
    always_comb begin
        unique case (kind)
            FLOW_BRANCH:              target = pc_inc + br_sext;
            FLOW_CALL_REL:            target = pc_inc + cl_sext;
            FLOW_JUMP, FLOW_CALL_REG: target = base_val;
            default:                  target = pc_inc;
        endcase
    end
endmodule

// File: rtl/npc_trap_seq.sv
// Module: npc_trap_seq
// Runs the two-step trap: it latches the vector, holds one read request
// open, and signals done in the cycle the read data is valid.
// Assumes: start is only pulsed while no request is open.
module npc_trap_seq #(
    parameter int XLEN  = 16,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VEC_W-1:0] vector,
    input  logic             rd_valid,
    output logic             waiting,
    output logic             done,
    output logic [XLEN-1:0]  rd_addr
);
    localparam int PAD = XLEN - VEC_W;

    logic [VEC_W-1:0] vec_q;

    // Open the request on start and close it when data returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
            vec_q   <= '0;
        end else if (start) begin
            waiting <= 1'b1;
            vec_q   <= vector;
        end else if (waiting && rd_valid) begin
            waiting <= 1'b0;
        end
    end

    assign done    = waiting && rd_valid;
    assign rd_addr = {{PAD{1'b0}}, vec_q};

    // R6: an open request stays open until data arrives
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && !rd_valid |=> waiting);
    // R7: the request closes after the data cycle
    a_r7_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && rd_valid |=> !waiting);
endmodule

// File: rtl/npc_unit.sv
// Module: npc_unit (top)
// Holds the program counter and updates it on each execute strobe from
// the decoded flow class. It starts the trap sequence and raises the
// register-7 link write for calls and for completed traps.
// Assumes: base_val already holds the register named by instr[8:6].
module npc_unit
    import npc_pkg::*;
#(
    parameter int              XLEN     = 16,
    parameter int              VEC_W    = 8,
    parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_en,
    input  logic [15:0]     instr,
    input  logic [2:0]      flags_nzp,
    input  logic [XLEN-1:0] base_val,
    output logic [XLEN-1:0] pc,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            mem_rd_req,
    output logic [XLEN-1:0] mem_rd_addr,
    input  logic [XLEN-1:0] mem_rd_data,
    input  logic            mem_rd_valid
);
    flow_e           kind;
    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] target;
    logic            accept;
    logic            trap_start;
    logic            trap_done;
    logic            waiting;
    logic            is_call;

    assign pc_inc = pc + 1'b1;

    npc_decode u_decode (
        .instr_hi  (instr[15:9]),
        .flags_nzp (flags_nzp),
        .kind      (kind)
    );

    npc_target #(.XLEN(XLEN)) u_target (
        .pc_inc      (pc_inc),
        .offset_bits (instr[10:0]),
        .base_val    (base_val),
        .kind        (kind),
        .target      (target)
    );

    npc_trap_seq #(.XLEN(XLEN), .VEC_W(VEC_W)) u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (trap_start),
        .vector   (instr[VEC_W-1:0]),
        .rd_valid (mem_rd_valid),
        .waiting  (waiting),
        .done     (trap_done),
        .rd_addr  (mem_rd_addr)
    );

    assign accept     = exec_en && !waiting;
    assign trap_start = accept && (kind == FLOW_TRAP);
    assign is_call    = (kind == FLOW_CALL_REL) || (kind == FLOW_CALL_REG);
    assign link_we    = (accept && is_call) || trap_done;
    assign link_data  = pc_inc;
    assign mem_rd_req = waiting;

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_PC;
        else if (trap_done)
            pc <= mem_rd_data;
        else if (accept && kind != FLOW_TRAP)
            pc <= target;
    end

    // R8: no strobe and no open request keeps the PC
    a_r8_pc_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en && !mem_rd_req |=> $stable(pc));
    // R6: while waiting for vector data the PC holds
    a_r6_pc_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> $stable(pc));
    // R7: returning vector data lands in the PC
    a_r7_vector_load: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_valid |=> pc == $past(mem_rd_data));
    // R7: link write accompanies vector data
    a_r7_link_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_valid |-> link_we);
    // R4: a jump never requests a link write
    a_r4_jump_no_link: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && !mem_rd_req && instr[15:12] == OP_JUMP |-> !link_we);
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/100ps
module npc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [15:0] instr = '0;
    logic [2:0]  flags_nzp = 3'b010;
    logic [15:0] base_val = '0;
    logic [15:0] pc;
    logic        link_we;
    logic [15:0] link_data;
    logic        mem_rd_req;
    logic [15:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        mem_rd_valid = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] pc;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    bit   pend = 1'b0;

    always #2.5 clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
        .flags_nzp(flags_nzp), .base_val(base_val), .pc(pc),
        .link_we(link_we), .link_data(link_data), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_rd_valid(mem_rd_valid)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: after each edge, pop the expected PC and compare
    always @(posedge clk) begin
        #1;
        if (pend) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, pc, e.pc);
            pend = 1'b0;
        end
    end

    // Driver: present one strobe, check link outputs, queue the expected PC
    task automatic drive(input logic [15:0] ins, input logic [2:0] fl, input logic [15:0] bv,
                         input logic [15:0] exp_pc, input logic exp_lwe,
                         input logic [15:0] exp_ld, input string tag);
        @(negedge clk);
        instr = ins; flags_nzp = fl; base_val = bv; exec_en = 1'b1;
        #1;
        check({tag, " link_we"}, {15'd0, link_we}, {15'd0, exp_lwe});
        if (exp_lwe) check({tag, " link_data"}, link_data, exp_ld);
        sb_q.push_back('{exp_pc, tag});
        pend = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exec_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc, 16'h3000);
        check("R1 reset req", {15'd0, mem_rd_req}, 16'd0);
        check("R1 reset link", {15'd0, link_we}, 16'd0);
        rst_n = 1'b1;

        drive(16'h0405, 3'b010, 16'h0, 16'h3006, 1'b0, 16'h0, "R2 branch z taken +5");
        drive(16'h0805, 3'b010, 16'h0, 16'h3007, 1'b0, 16'h0, "R2 branch n not taken");
        drive(16'h0003, 3'b001, 16'h0, 16'h3008, 1'b0, 16'h0, "R3 mask 000 never");
        drive(16'h0FFD, 3'b100, 16'h0, 16'h3006, 1'b0, 16'h0, "R3 mask 111 always -3");

        // R8: no strobe, PC holds; stray read data while idle is ignored
        @(negedge clk);
        instr = 16'hC080; base_val = 16'h7777; mem_rd_valid = 1'b1; mem_rd_data = 16'h1234;
        #1 check("R8 idle valid no link", {15'd0, link_we}, 16'd0);
        @(posedge clk); #1 check("R8 idle hold", pc, 16'h3006);
        @(negedge clk); mem_rd_valid = 1'b0;

        drive(16'hC080, 3'b010, 16'h4000, 16'h4000, 1'b0, 16'h0, "R4 jump base");
        drive(16'h4810, 3'b010, 16'h0, 16'h4011, 1'b1, 16'h4001, "R5 call relative");
        // R5: call through R7, old R7 read while new link written
        drive(16'h41C0, 3'b010, 16'h5000, 16'h5000, 1'b1, 16'h4012, "R5 call via R7");
        drive(16'h1000, 3'b010, 16'h0, 16'h5001, 1'b0, 16'h0, "R9 other opcode");

        // R6: trap start leaves PC, opens request
        drive(16'hF025, 3'b010, 16'h0, 16'h5001, 1'b0, 16'h0, "R6 trap start");
        check("R6 req open", {15'd0, mem_rd_req}, 16'd1);
        check("R6 req addr", mem_rd_addr, 16'h0025);
        // R8: strobes during the wait have no effect
        drive(16'hC080, 3'b010, 16'h0AAA, 16'h5001, 1'b0, 16'h0, "R8 strobe ignored 1");
        drive(16'h4810, 3'b010, 16'h0AAA, 16'h5001, 1'b0, 16'h0, "R8 strobe ignored 2");
        check("R6 req still open", {15'd0, mem_rd_req}, 16'd1);
        // R7: vector data returns
        @(negedge clk);
        mem_rd_data = 16'h0600; mem_rd_valid = 1'b1;
        #1;
        check("R7 link_we", {15'd0, link_we}, 16'd1);
        check("R7 link_data", link_data, 16'h5002);
        @(posedge clk); #1 check("R7 pc from vector", pc, 16'h0600);
        @(negedge clk); mem_rd_valid = 1'b0;
        check("R7 req dropped", {15'd0, mem_rd_req}, 16'd0);

        drive(16'hC1C0, 3'b001, 16'h5002, 16'h5002, 1'b0, 16'h0, "R4 return via R7");

        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule